// File: doc/BRIEF.md
# Fault-Tolerant Coded Adder/Subtractor

This block adds or subtracts two 4-bit values that arrive as single-error-correcting (7,4) Hamming codewords. It returns the result as a (7,4) codeword that stays correctable to the true result even if one fault occurs anywhere inside the arithmetic. Each input codeword first passes through its own corrector. The corrected data then feeds several independent adder copies. One copy produces the result data bits. Each of the three parity bits comes from a separate copy of its own, which may be trimmed to the sum bits that parity bit covers. The result parity is therefore never derived from the primary sum, so a single fault can damage at most one bit of the result codeword.

A single output corrector computes the syndrome of the assembled result and repairs the flipped bit. The raw codeword, the corrected data, the syndrome and an uncoded carry/no-borrow flag are registered together, with one cycle of latency. A per-copy fault-injection mask, held at zero in service, lets one sum bit of any copy be flipped to exercise the fault path.

Codeword layout, bit index 0 to 6, uses Hamming positions 1 to 7: bit0=p0, bit1=p1, bit2=d0, bit3=p2, bit4=d1, bit5=d2, bit6=d3. The parity bits are p0=d0^d1^d3, p1=d0^d2^d3 and p2=d1^d2^d3. The syndrome is {s2,s1,s0}. Its nonzero value is the position of the flipped bit, so bit index = syndrome-1.

Top module: `hpa_add4`

## Requirements
- R1: With sub=0, q_data equals (A+B+cin) mod 16 one clock after the operands are presented, where A and B are the data fields of in_a and in_b.
- R2: With sub=1, q_data equals (A-B) mod 16 one clock later, and cin has no effect.
- R3: q_cout is bit 4 of A+B+cin when adding, and is 1 exactly when A>=B when subtracting (carry out of A+~B+1).
- R4: With fault_inj all zero, q_cw is the exact encoding of the result in the stated layout and q_syn is 0.
- R5: A single flipped bit anywhere in in_a or in_b is corrected before the arithmetic, so the outputs are the same as for the clean codewords.
- R6: Flipping sum bit j of the primary copy (fault_inj[j], j=0..3) leaves q_data correct and makes q_syn the position of data bit dj: 3, 5, 6 or 7 for j=0..3.
- R7: Flipping sum bit j of parity copy k (fault_inj[4(k+1)+j], k=0..2) leaves q_data correct. It makes q_syn equal to 2^k if dj is covered by parity pk; otherwise it has no effect on any output.
- R8: While rst_n is low, q_cw, q_data, q_syn and q_cout are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 7 | Operand A codeword |
| in_b | input | 7 | Operand B codeword |
| sub | input | 1 | 1 selects A-B, 0 selects A+B+cin |
| cin | input | 1 | Carry input for addition |
| fault_inj | input | 16 | Sum-bit flip mask, 4 bits per copy (copy 0 primary, copies 1-3 parity) |
| q_cw | output | 7 | Registered result codeword before correction |
| q_data | output | 4 | Registered corrected result data |
| q_syn | output | 3 | Registered syndrome of the result codeword |
| q_cout | output | 1 | Registered carry (add) or no-borrow (sub) flag |

## Verification
The hardest condition to produce is an internal fault: a single wrong sum bit inside one specific adder copy, which no operand pattern can cause on its own. The stimulus reaches it through the fault-injection mask. For both operations and all 256 operand pairs, the bench walks a single flipped bit across every position of every copy. This includes the bits a trimmed parity copy never computes, which must have no effect. Random operand codewords with one flipped input bit are then mixed in to exercise the input correctors separately from the internal faults.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
   localparam int HP_DW = 4;
   localparam int HP_PW = 3;
   localparam int HP_CW = HP_DW + HP_PW;

   // data bits covered by parity k
   function automatic logic [3:0] hp_pmask(input int k);
      case (k)
         0:       return 4'b1011;
         1:       return 4'b1101;
         default: return 4'b1110;
      endcase
   endfunction

   function automatic logic [6:0] hp_place(input logic [3:0] d, input logic [2:0] p);
      return {d[3], d[2], d[1], p[2], d[0], p[1], p[0]};
   endfunction

   function automatic logic [3:0] hp_data(input logic [6:0] cw);
      return {cw[6], cw[5], cw[4], cw[2]};
   endfunction

   function automatic logic [6:0] hp_encode(input logic [3:0] d);
      return hp_place(d, {^(d & hp_pmask(2)), ^(d & hp_pmask(1)), ^(d & hp_pmask(0))});
   endfunction

   function automatic logic [2:0] hp_syndrome(input logic [6:0] cw);
      logic [2:0] s;
      s[0] = cw[0] ^ cw[2] ^ cw[4] ^ cw[6];
      s[1] = cw[1] ^ cw[2] ^ cw[5] ^ cw[6];
      s[2] = cw[3] ^ cw[4] ^ cw[5] ^ cw[6];
      return s;
   endfunction

   function automatic logic [6:0] hp_correct(input logic [6:0] cw);
      logic [2:0] s;
      s = hp_syndrome(cw);
      if (s == 3'd0) return cw;
      return cw ^ (7'd1 << (s - 3'd1));
   endfunction
endpackage

// File: rtl/hpa_in_fix.sv
module hpa_in_fix
   import hpa_pkg::*;
(
   input  logic [HP_CW-1:0] cw,
   output logic [HP_DW-1:0] data
);
   assign data = hp_data(hp_correct(cw));
endmodule

// File: rtl/hpa_add_copy.sv
// One adder/subtractor copy. Each carry is formed by its own unrolled
// generate/propagate chain, so no carry node is shared between bit slices.
module hpa_add_copy #(
   parameter int             DW   = 4,
   parameter logic [DW-1:0]  KEEP = '1,
   parameter bit             TRIM = 1'b0
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          sub,
   input  logic          cin,
   output logic [DW:0]   res
);
   logic [DW-1:0] bx, g, p;
   logic          c0;

   assign bx = b ^ {DW{sub}};
   assign c0 = sub | cin;
   assign g  = a & bx;
   assign p  = a ^ bx;

   function automatic logic carry_at(input int n, input logic [DW-1:0] gg,
                                     input logic [DW-1:0] pp, input logic cc);
      logic r;
      r = cc;
      for (int j = 0; j < n; j++) r = gg[j] | (pp[j] & r);
      return r;
   endfunction

   generate
      for (genvar i = 0; i < DW; i++) begin : g_bit
         if (TRIM && !KEEP[i]) begin : g_drop
            assign res[i] = 1'b0;
         end else begin : g_sum
            assign res[i] = p[i] ^ carry_at(i, g, p, c0);
         end
      end
   endgenerate

   assign res[DW] = carry_at(DW, g, p, c0);
endmodule

// File: rtl/hpa_add4.sv
module hpa_add4
   import hpa_pkg::*;
#(
   parameter int DW      = 4,
   parameter bit TRIM    = 1'b1,
   parameter bit COUT_EN = 1'b1,
   localparam int PW     = HP_PW,
   localparam int CW     = DW + PW,
   localparam int NCOPY  = PW + 1,
   localparam int NF     = NCOPY * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] in_a,
   input  logic [CW-1:0] in_b,
   input  logic          sub,
   input  logic          cin,
   input  logic [NF-1:0] fault_inj,
   output logic [CW-1:0] q_cw,
   output logic [DW-1:0] q_data,
   output logic [2:0]    q_syn,
   output logic          q_cout
);
   generate
      if (DW != HP_DW) begin : g_bad_width
         $error("hpa_add4: DW must be %0d for the (7,4) code", HP_DW);
      end
   endgenerate

   logic [DW-1:0] a_d, b_d;
   logic [DW:0]   sums   [NCOPY];
   logic [DW:0]   sums_f [NCOPY];
   logic [PW-1:0] par;
   logic [CW-1:0] res_cw, fix_cw;
   logic [2:0]    syn;
   logic          cout_d;

   hpa_in_fix u_fix_a (.cw(in_a), .data(a_d));
   hpa_in_fix u_fix_b (.cw(in_b), .data(b_d));

   // copy 0: result data bits
   hpa_add_copy #(.DW(DW), .KEEP('1), .TRIM(1'b0)) u_main (
      .a(a_d), .b(b_d), .sub(sub), .cin(cin), .res(sums[0])
   );

   // copies 1..PW: one per parity bit, never shared with the data path
   generate
      for (genvar k = 0; k < PW; k++) begin : g_par
         localparam logic [DW-1:0] MSK = hp_pmask(k);
         hpa_add_copy #(.DW(DW), .KEEP(MSK), .TRIM(TRIM)) u_cp (
            .a(a_d), .b(b_d), .sub(sub), .cin(cin), .res(sums[k+1])
         );
         assign par[k] = ^(sums_f[k+1] & {1'b0, MSK});
      end
      for (genvar c = 0; c < NCOPY; c++) begin : g_flt
         assign sums_f[c] = sums[c] ^ {1'b0, fault_inj[c*DW +: DW]};
      end
   endgenerate

   assign res_cw = hp_place(sums_f[0][DW-1:0], par);
   assign syn    = hp_syndrome(res_cw);
   assign fix_cw = hp_correct(res_cw);
   assign cout_d = COUT_EN ? sums_f[0][DW] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_cw   <= '0;
         q_data <= '0;
         q_syn  <= '0;
         q_cout <= 1'b0;
      end else begin
         q_cw   <= res_cw;
         q_data <= hp_data(fix_cw);
         q_syn  <= syn;
         q_cout <= cout_d;
      end
   end
endmodule

// File: rtl/hpa_add4_chk.sv
module hpa_add4_chk
   import hpa_pkg::*;
#(
   parameter int DW      = 4,
   parameter bit COUT_EN = 1'b1,
   localparam int CW     = DW + HP_PW,
   localparam int NF     = (HP_PW + 1) * DW
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] in_a,
   input logic [CW-1:0] in_b,
   input logic          sub,
   input logic          cin,
   input logic [NF-1:0] fault_inj,
   input logic [CW-1:0] q_cw,
   input logic [DW-1:0] q_data,
   input logic [2:0]    q_syn,
   input logic          q_cout
);
   assert_add_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub && $onehot0(fault_inj))
      |=> q_data == $past(hp_data(hp_correct(in_a)) + hp_data(hp_correct(in_b)) + {3'd0, cin}));

   assert_sub_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sub && $onehot0(fault_inj))
      |=> q_data == $past(hp_data(hp_correct(in_a)) - hp_data(hp_correct(in_b))));

   generate
      if (COUT_EN) begin : g_cout
         assert_carry_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!sub && $onehot0(fault_inj))
            |=> q_cout == $past(({1'b0, hp_data(hp_correct(in_a))}
                                 + {1'b0, hp_data(hp_correct(in_b))} + {4'd0, cin}) >> 4));
      end
   endgenerate

   assert_clean_codeword_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_inj == '0) |=> (q_syn == 3'd0 && hp_syndrome(q_cw) == 3'd0));

   assert_data_fault_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($onehot(fault_inj[DW-1:0]) && fault_inj[NF-1:DW] == '0)
      |=> (q_syn == 3'd3 || q_syn == 3'd5 || q_syn == 3'd6 || q_syn == 3'd7));

   assert_parity_fault_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_inj[DW-1:0] == '0 && $onehot(fault_inj))
      |=> $countones(q_syn) <= 1);
endmodule

bind hpa_add4 hpa_add4_chk #(.DW(DW), .COUT_EN(COUT_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .sub(sub), .cin(cin),
   .fault_inj(fault_inj), .q_cw(q_cw), .q_data(q_data), .q_syn(q_syn), .q_cout(q_cout)
);

// File: tb/tb_hpa_add4.sv
module tb_hpa_add4;
   localparam int CLK_PERIOD = 10;

   logic        clk, rst_n, sub, cin;
   logic [6:0]  in_a, in_b;
   logic [15:0] fault_inj;
   logic [6:0]  q_cw;
   logic [3:0]  q_data;
   logic [2:0]  q_syn;
   logic        q_cout;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   hpa_add4 dut (
      .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .sub(sub), .cin(cin),
      .fault_inj(fault_inj), .q_cw(q_cw), .q_data(q_data), .q_syn(q_syn), .q_cout(q_cout)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [3:0] cover_of(input int k);
      if (k == 0) return 4'b1011;
      if (k == 1) return 4'b1101;
      return 4'b1110;
   endfunction

   function automatic logic [6:0] enc(input logic [3:0] d);
      logic [6:0] w;
      w = '0;
      w[2] = d[0]; w[4] = d[1]; w[5] = d[2]; w[6] = d[3];
      w[0] = d[0] ^ d[1] ^ d[3];
      w[1] = d[0] ^ d[2] ^ d[3];
      w[3] = d[1] ^ d[2] ^ d[3];
      return w;
   endfunction

   function automatic int dpos(input int j);
      case (j)
         0: return 3;
         1: return 5;
         2: return 6;
         default: return 7;
      endcase
   endfunction

   // expected error position for a single-bit fault mask (0 = none)
   function automatic int fault_pos(input logic [15:0] f);
      for (int i = 0; i < 16; i++) begin
         if (f[i]) begin
            if (i < 4) return dpos(i);
            if (cover_of(i/4 - 1)[i%4]) return 1 << (i/4 - 1);
            return 0;
         end
      end
      return 0;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic run(input logic [3:0] a, input logic [3:0] b, input logic s, input logic c,
                      input logic [6:0] ea, input logic [6:0] eb, input logic [15:0] f,
                      input string req);
      logic [4:0] full;
      logic [3:0] r;
      logic       co;
      int         pos;
      in_a = enc(a) ^ ea;
      in_b = enc(b) ^ eb;
      sub = s; cin = c; fault_inj = f;
      if (s) full = {1'b0, a} + {1'b0, ~b} + 5'd1;
      else   full = {1'b0, a} + {1'b0, b} + {4'd0, c};
      r   = full[3:0];
      co  = full[4];
      pos = fault_pos(f);
      @(negedge clk);
      check(req, int'(q_data), int'(r));
      check({req, " R3 cout"}, int'(q_cout), int'(co));
      check({req, " R4/R6/R7 syn"}, int'(q_syn), pos);
      check({req, " R4/R6/R7 cw"}, int'(q_cw),
            int'(enc(r) ^ (pos == 0 ? 7'd0 : (7'd1 << (pos - 1)))));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; sub = 1'b0; cin = 1'b0; fault_inj = '0;
      in_a = enc(4'd9); in_b = enc(4'd7);
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8 cw",   int'(q_cw),   0);
      check("R8 data", int'(q_data), 0);
      check("R8 syn",  int'(q_syn),  0);
      check("R8 cout", int'(q_cout), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      run(4'd15, 4'd0,  1'b0, 1'b1, 7'd0, 7'd0, 16'd0, "R1 wrap");
      run(4'd15, 4'd15, 1'b0, 1'b1, 7'd0, 7'd0, 16'd0, "R1 max");
      run(4'd0,  4'd1,  1'b1, 1'b0, 7'd0, 7'd0, 16'd0, "R2 borrow");
      run(4'd5,  4'd5,  1'b1, 1'b1, 7'd0, 7'd0, 16'd0, "R2 cin ignored");
      run(4'd9,  4'd3,  1'b1, 1'b1, 7'd0, 7'd0, 16'd0, "R2 cin ignored");
      run(4'd6,  4'd6,  1'b0, 1'b0, 7'h40, 7'h01, 16'd0, "R5 both flipped");

      // exhaustive sweep: every pair, both operations, each single fault position
      for (int op = 0; op < 2; op++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               for (int f = -1; f < 16; f++) begin
                  logic [15:0] m;
                  string tag;
                  m = (f < 0) ? 16'd0 : (16'd1 << f);
                  if (f < 0)      tag = (op == 1) ? "R2" : "R1";
                  else if (f < 4) tag = "R6";
                  else            tag = "R7";
                  run(4'(a), 4'(b), op[0], 1'($urandom_range(1)), 7'd0, 7'd0, m, tag);
               end
            end
         end
      end

      // random operands with one corrupted input bit
      for (int n = 0; n < 600; n++) begin
         logic [6:0] ea, eb;
         int sel;
         ea = '0; eb = '0;
         sel = $urandom_range(7);
         if (sel < 7) begin
            if ($urandom_range(1) == 0) ea = 7'd1 << sel;
            else                        eb = 7'd1 << sel;
         end
         run(4'($urandom_range(15)), 4'($urandom_range(15)), 1'($urandom_range(1)),
             1'($urandom_range(1)), ea, eb, 16'd0, "R5");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule